// File: doc/BRIEF.md
# GPIO Interrupt Slot Mapper

This block funnels a wide bank of general-purpose input pins into a small, fixed set of interrupt slots that feed a parent interrupt controller. Software gives each slot one pin index, an enable bit and a two-bit sense code: rising edge, falling edge, high level or low level. Every pin passes through a two-flop synchroniser. Each slot then watches its chosen pin and latches an event into its own status bit. While that bit is set, the slot's request line to the parent is held high.

Software services a slot by writing a zero to its status bit. Writing a one leaves the bit untouched. A slot in a level mode keeps setting its bit for as long as the active level lasts. The register port is a plain 32-bit write/read port with a combinational read. It has no stream traffic, so it carries no valid/ready handshake and applies no back-pressure.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every status bit and every request output is 0, and all configuration registers read back as 0 (every slot disabled, sense code 0).
- R2: Slot n owns an 8-bit select field in the word at 0x30 + 4*(n/4), starting at bit 8*(n mod 4). Bit 7 of the field enables the slot and bits 6:0 hold the pin index. Written fields read back unchanged.
- R3: Sense codes for slots 0 to 15 sit at 0x24 and those for slots 16 to 31 at 0x28, with slot n at bits 2m+1:2m where m = n mod 16. Code 0 is rising edge, 1 is falling edge, 2 is high level and 3 is low level. Written values read back unchanged.
- R4: In rising mode, a 0-to-1 change on the selected pin sets the slot's status bit. The request is high after the third rising clock edge following the pin change, and still low after the second.
- R5: In falling mode, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R6: In a level mode, the status bit is set on every cycle in which the selected pin sits at the active level. Once the level is gone, one clear leaves the bit at 0.
- R7: Status is at 0x20, with slot n at bit n. Writing 0 to a bit clears it and writing 1 to a bit has no effect.
- R8: When a clear and a new event for the same slot fall in the same cycle, the bit stays set.
- R9: A slot whose enable bit is 0 never sets its status bit, whatever its pin does.
- R10: Moving a slot onto a different pin reports no edge from the switch itself. Later real edges on the new pin are still detected.
- R11: A pin index of 123 or more selects a constant-low input.
- R12: Request output n equals status bit n. It is active high and stays high until the bit is cleared.
- R13: Several slots may select the same pin, and each one applies its own sense mode independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 123 | Asynchronous GPIO inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 32 | Level-high request per slot to the parent |

## Verification
The bench aims at the points where a mapper most often goes wrong.

- **Latency count.** It counts the exact edge at which a request appears. A design with one synchroniser stage too few or too many shows up a cycle early or late.
- **Clear-versus-set race.** It writes a clear while a level source is still active. A design where the clear wins drops a request whose source is still present.
- **Switching pins.** It moves a rising-edge slot from a low pin to a high pin. A design that keeps the old pin's history raises a phantom interrupt.
- **Disabled slots and unused pin indices.** It drives the watched pins high on a disabled slot and on a slot with an out-of-range index. A design with a bad enable gate or mux bounds raises requests that should never appear.
- **Status-write polarity.** It writes all ones to the status register. A design with inverted write polarity clears bits that should have survived.

// File: rtl/girq_pkg.sv
package girq_pkg;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  localparam int REG_W          = 32;
  localparam int SEL_FIELD_W    = 8;
  localparam int SEL_EN_BIT     = 7;
  localparam int SEL_PER_WORD   = REG_W / SEL_FIELD_W;
  localparam int SENSE_W        = 2;
  localparam int SENSE_PER_WORD = REG_W / SENSE_W;

  localparam logic [7:0] STATUS_OFS = 8'h20;
  localparam logic [7:0] SENSE_OFS  = 8'h24;
  localparam logic [7:0] SELECT_OFS = 8'h30;

endpackage

// File: rtl/girq_sync.sv
module girq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[k] <= '0;
      end else if (k == 0) begin
        stage_q[k] <= async_i;
      end else begin
        stage_q[k] <= stage_q[(k == 0) ? 0 : k-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/girq_slot.sv
module girq_slot
  import girq_pkg::*;
#(
  parameter int NUM_PINS = 123,
  parameter int PIN_W    = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS-1:0]    pins_i,
  input  logic [SEL_FIELD_W-1:0] cfg_i,
  input  logic [SENSE_W-1:0]     sense_i,
  output logic                   hit_o
);

  localparam int PAD = 1 << PIN_W;

  logic [PAD-1:0]   pins_pad;
  logic [PIN_W-1:0] pin;
  logic             en, cur;
  logic             prev_q, armed_q;
  logic [PIN_W-1:0] pin_q;
  logic             hist_ok;

  assign pins_pad = PAD'(pins_i);   // unused indices read low
  assign en       = cfg_i[SEL_EN_BIT];
  assign pin      = cfg_i[PIN_W-1:0];
  assign cur      = pins_pad[pin];

  // Edge history counts only when the slot was enabled last cycle on the same pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pin_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= cur;
      pin_q   <= pin;
      armed_q <= en;
    end
  end

  assign hist_ok = armed_q && (pin_q == pin);

  always_comb begin
    hit_o = 1'b0;
    if (en) begin
      unique case (sense_i)
        SENSE_RISE: hit_o = hist_ok && !prev_q &&  cur;
        SENSE_FALL: hit_o = hist_ok &&  prev_q && !cur;
        SENSE_HIGH: hit_o =  cur;
        SENSE_LOW:  hit_o = !cur;
        default:    hit_o = 1'b0;
      endcase
    end
  end

  // R10: a pin switch must not itself look like an edge
  p_reselect_no_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sense_i[1] && (pin != $past(pin))) |-> !hit_o)
    else $error("reselect produced an edge");

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import girq_pkg::*;
#(
  parameter int NUM_PINS  = 123,
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  gpio_i,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [NUM_SLOTS-1:0] irq_o
);

  localparam int PIN_W       = $clog2(NUM_PINS);
  localparam int SEL_WORDS   = NUM_SLOTS / SEL_PER_WORD;
  localparam int SENSE_WORDS = (NUM_SLOTS + SENSE_PER_WORD - 1) / SENSE_PER_WORD;

  logic [NUM_PINS-1:0]    pins_s;
  logic [SEL_FIELD_W-1:0] sel_q   [NUM_SLOTS];
  logic [SENSE_W-1:0]     sense_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]   hit;
  logic [NUM_SLOTS-1:0]   status_q;
  logic [NUM_SLOTS-1:0]   clr_mask;
  logic                   stat_wr;

  girq_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(gpio_i), .sync_o(pins_s)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SEL_A =
      ADDR_W'(int'(SELECT_OFS) + 4 * (s / SEL_PER_WORD));
    localparam logic [ADDR_W-1:0] SNS_A =
      ADDR_W'(int'(SENSE_OFS) + 4 * (s / SENSE_PER_WORD));
    localparam int SEL_LSB = SEL_FIELD_W * (s % SEL_PER_WORD);
    localparam int SNS_LSB = SENSE_W * (s % SENSE_PER_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[s]   <= '0;
        sense_q[s] <= '0;
      end else if (reg_we) begin
        if (reg_addr == SEL_A) sel_q[s]   <= reg_wdata[SEL_LSB +: SEL_FIELD_W];
        if (reg_addr == SNS_A) sense_q[s] <= reg_wdata[SNS_LSB +: SENSE_W];
      end
    end

    girq_slot #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_s),
      .cfg_i(sel_q[s]), .sense_i(sense_q[s]), .hit_o(hit[s])
    );

    // R8: an event always lands, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit[s] |=> status_q[s]) else $error("event lost");

    // R7: writing a one leaves a set bit alone
    p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && status_q[s] && reg_wdata[s]) |=> status_q[s])
      else $error("write-1 cleared status");

    // R7: writing a zero clears when no event is pending
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !reg_wdata[s] && !hit[s]) |=> !status_q[s])
      else $error("clear ignored");

    // R9: status only rises for a slot that was enabled
    p_disabled_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[s]) |-> $past(sel_q[s][SEL_EN_BIT]))
      else $error("disabled slot set status");
  end

  assign stat_wr  = reg_we && (reg_addr == ADDR_W'(STATUS_OFS));
  assign clr_mask = stat_wr ? ~reg_wdata[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | hit;
  end

  assign irq_o = status_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(STATUS_OFS)) reg_rdata[NUM_SLOTS-1:0] = status_q;
    for (int k = 0; k < SENSE_WORDS; k++) begin
      if (reg_addr == ADDR_W'(int'(SENSE_OFS) + 4 * k)) begin
        for (int j = 0; j < SENSE_PER_WORD; j++) begin
          if (k * SENSE_PER_WORD + j < NUM_SLOTS)
            reg_rdata[SENSE_W*j +: SENSE_W] = sense_q[k * SENSE_PER_WORD + j];
        end
      end
    end
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (reg_addr == ADDR_W'(int'(SELECT_OFS) + 4 * w)) begin
        for (int j = 0; j < SEL_PER_WORD; j++)
          reg_rdata[SEL_FIELD_W*j +: SEL_FIELD_W] = sel_q[w * SEL_PER_WORD + j];
      end
    end
  end

endmodule

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;

  localparam int NP = 123;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] gpio = '0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] sel_sh  [NS];
  logic [1:0] mode_sh [NS];

  gpio_irq_router uut (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // {slot[4:0], pin[6:0], mode[1:0], v0, v1, exp}
  localparam logic [16:0] VECS [0:7] = '{
    {5'd0,  7'd5,   2'd0, 1'b0, 1'b1, 1'b1},  // R4 rise fires
    {5'd7,  7'd122, 2'd1, 1'b1, 1'b0, 1'b1},  // R5 fall fires
    {5'd13, 7'd64,  2'd0, 1'b1, 1'b0, 1'b0},  // R4 rise ignores fall
    {5'd18, 7'd33,  2'd2, 1'b0, 1'b1, 1'b1},  // R6 level high
    {5'd25, 7'd100, 2'd3, 1'b1, 1'b1, 1'b0},  // R6 level low, inactive
    {5'd31, 7'd0,   2'd1, 1'b0, 1'b1, 1'b0},  // R5 fall ignores rise
    {5'd16, 7'd77,  2'd3, 1'b1, 1'b0, 1'b1},  // R6 level low active
    {5'd4,  7'd9,   2'd2, 1'b0, 1'b0, 1'b0}   // R6 level high, inactive
  };

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_slot(int s, bit en, int pin, logic [1:0] mode);
    logic [31:0] w;
    int base;
    mode_sh[s] = mode;
    sel_sh[s]  = {en, 7'(pin)};
    base = (s / 16) * 16;
    w = '0;
    for (int j = 0; j < 16; j++) w[2*j +: 2] = mode_sh[base + j];
    wr(8'h24 + 8'(4 * (s / 16)), w);
    base = (s / 4) * 4;
    w = '0;
    for (int j = 0; j < 4; j++) w[8*j +: 8] = sel_sh[base + j];
    wr(8'h30 + 8'(4 * (s / 4)), w);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int s = 0; s < NS; s++) begin sel_sh[s] = '0; mode_sh[s] = '0; end
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    rd(8'h20, r); chk("R1 status", r, 32'h0);
    rd(8'h24, r); chk("R1 sense", r, 32'h0);
    rd(8'h3C, r); chk("R1 select", r, 32'h0);

    // R2 / R3 readback
    wr(8'h34, 32'h0A_7F_05_11);
    rd(8'h34, r); chk("R2 select readback", r, 32'h0A_7F_05_11);
    wr(8'h28, 32'hA5A5_1234);
    rd(8'h28, r); chk("R3 sense readback", r, 32'hA5A5_1234);
    wr(8'h34, 32'h0); wr(8'h28, 32'h0); step(1);

    // table of vectors: R4 R5 R6
    foreach (VECS[i]) begin
      int s, p;
      s = int'(VECS[i][16:12]);
      p = int'(VECS[i][11:5]);
      gpio = '0; gpio[p] = VECS[i][2];
      set_slot(s, 1'b1, p, VECS[i][4:3]);
      step(4);
      wr(8'h20, 32'h0);
      step(1);
      gpio[p] = VECS[i][1];
      step(3);
      chk($sformatf("R4/R5/R6 vector %0d", i), 32'(irq[s]), 32'(VECS[i][0]));
    end
    for (int s = 0; s < NS; s++) begin sel_sh[s] = '0; mode_sh[s] = '0; end
    for (int w = 0; w < 8; w++) wr(8'h30 + 8'(4 * w), 32'h0);
    wr(8'h24, 0); wr(8'h28, 0);
    gpio = '0; step(4); wr(8'h20, 32'h0);

    // R4 latency, R12 persistence, R7 write polarity
    set_slot(2, 1'b1, 40, 2'd0);
    step(4);
    gpio[40] = 1'b1;
    step(2); chk("R4 not before third edge", 32'(irq[2]), 32'h0);
    step(1); chk("R4 at third edge", 32'(irq[2]), 32'h1);
    step(5); chk("R12 request persists", 32'(irq[2]), 32'h1);
    wr(8'h20, 32'hFFFF_FFFF); step(1);
    rd(8'h20, r); chk("R7 write-1 no effect", r, 32'h0000_0004);
    wr(8'h20, 32'hFFFF_FFFB); step(1);
    rd(8'h20, r); chk("R7 write-0 clears", r, 32'h0);
    chk("R12 request follows status", 32'(irq[2]), 32'h0);

    // R8 set wins, R6 level re-set then clears
    set_slot(3, 1'b1, 41, 2'd2);
    gpio[41] = 1'b1; step(4);
    wr(8'h20, 32'h0); step(1);
    chk("R8 set wins over clear", 32'(irq[3]), 32'h1);
    gpio[41] = 1'b0; step(3);
    wr(8'h20, 32'h0); step(1);
    chk("R6 clears once level gone", 32'(irq[3]), 32'h0);

    // R9 disabled slot
    set_slot(5, 1'b0, 42, 2'd2);
    gpio[42] = 1'b1; step(5);
    chk("R9 disabled slot quiet", 32'(irq[5]), 32'h0);

    // R10 reselect no false edge
    set_slot(6, 1'b1, 50, 2'd0);
    gpio[50] = 1'b0; gpio[51] = 1'b1; step(4);
    wr(8'h20, 32'h0);
    set_slot(6, 1'b1, 51, 2'd0);
    step(4);
    chk("R10 no edge on reselect", 32'(irq[6]), 32'h0);
    gpio[51] = 1'b0; step(4);
    gpio[51] = 1'b1; step(3);
    chk("R10 real edge after reselect", 32'(irq[6]), 32'h1);

    // R11 out-of-range pin index
    set_slot(8, 1'b1, 125, 2'd2);
    gpio = '1; step(5);
    chk("R11 unused index reads low", 32'(irq[8]), 32'h0);

    // R13 shared pin
    gpio = '0;
    set_slot(9, 1'b1, 60, 2'd0);
    set_slot(10, 1'b1, 60, 2'd1);
    step(4); wr(8'h20, 32'h0);
    gpio[60] = 1'b1; step(3);
    chk("R13 rise slot on shared pin", 32'(irq[9]), 32'h1);
    chk("R13 fall slot on shared pin idle", 32'(irq[10]), 32'h0);
    gpio[60] = 1'b0; step(3);
    chk("R13 fall slot on shared pin", 32'(irq[10]), 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule